// File: doc/BRIEF.md
# Keyed-Disarm Watchdog Down-Counter

This block is a watchdog peripheral that sits on a simple 16-bit register bus. Software programs a start count, a clock divider setting and an auto-reload option, then sets the run bit. The counter steps down once per divided clock tick. When it steps from one to zero it signals expiry: a one-cycle interrupt pulse always, and a one-cycle reset-request pulse if the watchdog is armed. With auto-reload the count restarts from the last programmed value; without it the counter rests at zero.

Arming takes a single mode write with the top bit set. Disarming is guarded: it takes two mode writes in a fixed order, a priming value and then a confirming value as the very next mode write. Any other mode write in between cancels the priming. Writing a count of zero while armed is a software-triggered expiry that takes effect at once. The interrupt controller and the system reset generator that consume the two pulses are outside the block.

Top module: `kgw_top`

## Requirements
- R1: After reset the control register (byte offset 0x00) reads 0x0000, the count (offset 0x02) reads 0xFFFF, the mode register (offset 0x04) reads 0x0000, and both irq and rst_req are low.
- R2: A write to offset 0x02 sets both the counter and the stored reload value; a read of offset 0x02 returns the present count. Reads return data in the cycle after the rd_en cycle.
- R3: With control bit 7 (run) set and control bits 11:9 holding p, the counter steps down once every 2^(p+1) clocks. The expiry pulse appears 2^(p+1)*L clocks after the edge that sets run, where L is the loaded count.
- R4: A mode write with bit 15 set arms the watchdog; bit 15 of a mode read shows the armed state and every other bit reads 0.
- R5: Each expiry produces a one-cycle pulse on irq, whether or not the watchdog is armed.
- R6: rst_req pulses for one cycle together with irq only when the watchdog is armed at the expiry; while disarmed it stays low.
- R7: With control bit 8 (auto-reload) set, the counter reloads the last loaded value at expiry and the next expiry follows one full period later.
- R8: With auto-reload clear, the counter stays at zero after expiry and produces no further pulses.
- R9: Writing 0 to offset 0x02 while armed produces irq and rst_req in the cycle after the write edge. The same write while disarmed produces no pulse.
- R10: Mode write 0x00F5 followed by mode write 0x00A0 as the next mode write disarms the watchdog. A lone 0x00A0 has no effect.
- R11: A mode write other than 0x00A0 after 0x00F5 cancels the priming. The watchdog stays armed, so a later 0x00A0 has no effect.
- R12: Clearing the run bit freezes the count and stops all expiries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Byte offset of the register (0x00, 0x02, 0x04) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after rd_en |
| irq | output | 1 | One-cycle expiry interrupt pulse |
| rst_req | output | 1 | One-cycle reset request pulse, armed expiries only |

## Verification
A divider that miscounts by one clock shifts every expiry pulse by a multiple of the loaded count. The scoreboard times each pulse to the exact clock, so the error shows at the first expiry. A key machine that keeps a stale priming state or wrongly clears the armed bit is seen at the next mode read. It also shows as rst_req going missing or appearing at the next expiry. A reload register that is lost or overwritten shows as a wrong interval between the first and second auto-reload pulses.

// File: rtl/kgw_pkg.sv
package kgw_pkg;
   // byte offsets decoded on the register bus
   localparam int unsigned OFS_CTRL = 0;
   localparam int unsigned OFS_CNT  = 2;
   localparam int unsigned OFS_MODE = 4;

   // control field positions
   localparam int unsigned CTRL_RUN_BIT = 7;
   localparam int unsigned CTRL_AR_BIT  = 8;
   localparam int unsigned CTRL_PS_LO   = 9;

   // mode register values
   localparam int unsigned MODE_ARM_BIT = 15;
   localparam logic [15:0] KEY_PRIME    = 16'h00F5;
   localparam logic [15:0] KEY_CONFIRM  = 16'h00A0;

   typedef enum logic {
      KEY_IDLE   = 1'b0,
      KEY_PRIMED = 1'b1
   } key_state_e;
endpackage

// File: rtl/kgw_prescale.sv
module kgw_prescale #(
   parameter int unsigned PS_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            restart,
   input  logic [PS_W-1:0] psel,
   output logic            tick
);
   localparam int unsigned DIV_W = 2 ** PS_W;

   generate
      if (PS_W < 1 || PS_W > 5) begin : g_bad_ps
         $error("kgw_prescale: PS_W out of range");
      end
   endgenerate

   logic [DIV_W-1:0] pre_q;
   logic [DIV_W-1:0] mask;

   // mask holds p+1 low ones: terminal value of a 2^(p+1) divider
   generate
      for (genvar gi = 0; gi < DIV_W; gi++) begin : g_mask
         assign mask[gi] = (gi <= int'(psel));
      end
   endgenerate

   assign tick = run && !restart && ((pre_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
      end else if (!run || restart || tick) begin
         pre_q <= '0;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end

   // R3
   run_start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !$past(run)) |-> (pre_q == '0));
endmodule

// File: rtl/kgw_counter.sv
module kgw_counter #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned PS_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             auto_rl,
   input  logic [PS_W-1:0]  psel,
   input  logic             load_wr,
   input  logic [CNT_W-1:0] load_data,
   input  logic             armed,
   output logic [CNT_W-1:0] count,
   output logic             irq_o,
   output logic             rst_o
);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_INIT = '1;

   logic             tick;
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] reload_q;
   logic             step_exp;
   logic             force_exp;
   logic             expire;
   logic             irq_q;
   logic             rst_q;

   kgw_prescale #(.PS_W(PS_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (load_wr),
      .psel    (psel),
      .tick    (tick)
   );

   assign step_exp  = tick && (count_q == CNT_ONE);
   assign force_exp = load_wr && (load_data == '0) && armed;
   assign expire    = step_exp || force_exp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q  <= CNT_INIT;
         reload_q <= CNT_INIT;
      end else if (load_wr) begin
         count_q  <= load_data;
         reload_q <= load_data;
      end else if (tick && (count_q != '0)) begin
         if (step_exp && auto_rl) begin
            count_q <= reload_q;
         end else begin
            count_q <= count_q - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         rst_q <= 1'b0;
      end else begin
         irq_q <= expire;
         rst_q <= expire && armed;
      end
   end

   assign count = count_q;
   assign irq_o = irq_q;
   assign rst_o = rst_q;

   // R8
   hold_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_rl && (count_q == '0) && !load_wr) |=> (count_q == '0));
   // R12
   stopped_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !load_wr) |=> $stable(count_q));
   // R6
   rst_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |-> irq_q);
endmodule

// File: rtl/kgw_keyfsm.sv
module kgw_keyfsm
   import kgw_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              armed
);
   localparam logic [DATA_W-1:0] PRIME   = DATA_W'(KEY_PRIME);
   localparam logic [DATA_W-1:0] CONFIRM = DATA_W'(KEY_CONFIRM);

   key_state_e state_q;
   logic       armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= KEY_IDLE;
         armed_q <= 1'b0;
      end else if (mode_wr) begin
         if ((state_q == KEY_PRIMED) && (wdata == CONFIRM)) begin
            armed_q <= 1'b0;
            state_q <= KEY_IDLE;
         end else begin
            state_q <= (wdata == PRIME) ? KEY_PRIMED : KEY_IDLE;
            if (wdata[MODE_ARM_BIT]) begin
               armed_q <= 1'b1;
            end
         end
      end
   end

   assign armed = armed_q;

   // R4
   arm_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && wdata[MODE_ARM_BIT]) |=> armed_q);
   // R10
   lone_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && (wdata == CONFIRM) && (state_q == KEY_IDLE)) |=> (armed_q == $past(armed_q)));
   // R11
   no_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_wr |=> $stable(armed_q));
endmodule

// File: rtl/kgw_regs.sv
module kgw_regs
   import kgw_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned PS_W      = 3,
   parameter bit          REG_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  count,
   input  logic              armed,
   output logic              run,
   output logic              auto_rl,
   output logic [PS_W-1:0]   psel,
   output logic              load_wr,
   output logic              mode_wr,
   output logic [DATA_W-1:0] rdata
);
   generate
      if (CTRL_PS_LO + PS_W > DATA_W) begin : g_bad_fields
         $error("kgw_regs: prescale field does not fit the bus");
      end
      if (2 ** ADDR_W <= OFS_MODE) begin : g_bad_addr
         $error("kgw_regs: ADDR_W too narrow for the register map");
      end
   endgenerate

   logic              sel_ctrl, sel_cnt, sel_mode;
   logic              run_q, ar_q;
   logic [PS_W-1:0]   ps_q;
   logic [DATA_W-1:0] ctrl_word;
   logic [DATA_W-1:0] mode_word;
   logic [DATA_W-1:0] rd_word;

   assign sel_ctrl = (addr == ADDR_W'(OFS_CTRL));
   assign sel_cnt  = (addr == ADDR_W'(OFS_CNT));
   assign sel_mode = (addr == ADDR_W'(OFS_MODE));

   assign load_wr = wr_en && sel_cnt;
   assign mode_wr = wr_en && sel_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         ar_q  <= 1'b0;
         ps_q  <= '0;
      end else if (wr_en && sel_ctrl) begin
         run_q <= wdata[CTRL_RUN_BIT];
         ar_q  <= wdata[CTRL_AR_BIT];
         ps_q  <= wdata[CTRL_PS_LO +: PS_W];
      end
   end

   always_comb begin
      ctrl_word                     = '0;
      ctrl_word[CTRL_RUN_BIT]       = run_q;
      ctrl_word[CTRL_AR_BIT]        = ar_q;
      ctrl_word[CTRL_PS_LO +: PS_W] = ps_q;
      mode_word                     = '0;
      mode_word[MODE_ARM_BIT]       = armed;
      if (sel_ctrl) begin
         rd_word = ctrl_word;
      end else if (sel_cnt) begin
         rd_word = DATA_W'(count);
      end else if (sel_mode) begin
         rd_word = mode_word;
      end else begin
         rd_word = '0;
      end
   end

   generate
      if (REG_RDATA) begin : g_rd_reg
         logic [DATA_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rdata_q <= '0;
            end else if (rd_en) begin
               rdata_q <= rd_word;
            end
         end
         assign rdata = rdata_q;
      end else begin : g_rd_comb
         assign rdata = rd_en ? rd_word : '0;
      end
   endgenerate

   assign run     = run_q;
   assign auto_rl = ar_q;
   assign psel    = ps_q;
endmodule

// File: rtl/kgw_top.sv
module kgw_top #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned PS_W      = 3,
   parameter bit          REG_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq,
   output logic              rst_req
);
   generate
      if (DATA_W < 16) begin : g_bad_data
         $error("kgw_top: DATA_W must be at least 16");
      end
      if (CNT_W > DATA_W || CNT_W < 2) begin : g_bad_cnt
         $error("kgw_top: CNT_W must lie between 2 and DATA_W");
      end
   endgenerate

   logic             run, auto_rl, load_wr, mode_wr, armed;
   logic [PS_W-1:0]  psel;
   logic [CNT_W-1:0] count;

   kgw_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
      .PS_W(PS_W), .REG_RDATA(REG_RDATA)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .addr    (addr),
      .wdata   (wdata),
      .count   (count),
      .armed   (armed),
      .run     (run),
      .auto_rl (auto_rl),
      .psel    (psel),
      .load_wr (load_wr),
      .mode_wr (mode_wr),
      .rdata   (rdata)
   );

   kgw_keyfsm #(.DATA_W(DATA_W)) u_key (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_wr (mode_wr),
      .wdata   (wdata),
      .armed   (armed)
   );

   kgw_counter #(.CNT_W(CNT_W), .PS_W(PS_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .auto_rl   (auto_rl),
      .psel      (psel),
      .load_wr   (load_wr),
      .load_data (wdata[CNT_W-1:0]),
      .armed     (armed),
      .count     (count),
      .irq_o     (irq),
      .rst_o     (rst_req)
   );

   // R9
   zero_load_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_wr && (wdata[CNT_W-1:0] == '0) && armed) |=> (irq && rst_req));
   // R6
   disarmed_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> !rst_req);
endmodule

// File: tb/test_kgw_top.sv
module test_kgw_top;
   typedef struct {
      longint     cyc;
      bit         rst;
      string      req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic        irq, rst_req;

   longint cyc = 0;
   int     n_chk = 0;
   int     n_fail = 0;
   int     n_pulse = 0;
   exp_t   exp_q[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   kgw_top i_kgw_top (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
   );

   task automatic check(input string req, input longint act, input longint expv);
      n_chk++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
      end
   endtask

   task automatic bus_wr(input logic [2:0] a, input logic [15:0] d, output longint stamp);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      stamp = cyc;
   endtask

   task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(posedge clk);
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic expect_pulse(input longint c, input bit r, input string req);
      exp_t e;
      e.cyc = c; e.rst = r; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic drain(input int max_cyc);
      for (int i = 0; i < max_cyc && exp_q.size() != 0; i++) @(negedge clk);
      repeat (3) @(negedge clk);
      n_chk++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL %s missing expiry: actual=none expected cycle %0d",
                  exp_q[0].req, exp_q[0].cyc);
         exp_q.delete();
      end
   endtask

   // monitor: pops expected pulses and compares time and reset flag
   always @(negedge clk) begin
      longint c;
      bit     i_s, r_s;
      c = cyc; i_s = irq; r_s = rst_req;
      #1;
      if (rst_n && (i_s || r_s)) begin
         n_pulse++;
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R8/R12 unexpected pulse at cycle %0d: actual irq=%0b rst=%0b expected none",
                     c, i_s, r_s);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (!i_s || c != e.cyc || r_s != e.rst) begin
               n_fail++;
               $display("FAIL %s pulse: actual cycle=%0d irq=%0b rst=%0b expected cycle=%0d irq=1 rst=%0b",
                        e.req, c, i_s, r_s, e.cyc, e.rst);
            end
         end
      end
   end

   initial begin
      #(4 * 150000);
      n_fail++; n_chk++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      longint t, t2;
      logic [15:0] d, d2;
      int p0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq", irq, 0);
      check("R1 rst_req", rst_req, 0);
      bus_rd(3'd0, d); check("R1 ctrl", d, 16'h0000);
      bus_rd(3'd2, d); check("R1 count", d, 16'hFFFF);
      bus_rd(3'd4, d); check("R1 mode", d, 16'h0000);

      // R2 load and read back
      bus_wr(3'd2, 16'd6, t);
      bus_rd(3'd2, d); check("R2 count", d, 16'd6);

      // R3 R5 R6 disarmed expiry, p=0, L=4
      bus_wr(3'd2, 16'd4, t);
      bus_wr(3'd0, 16'h0080, t);
      expect_pulse(t + 8, 1'b0, "R3");
      drain(40);
      bus_wr(3'd0, 16'h0000, t);

      // R4 arm
      bus_wr(3'd4, 16'h8000, t);
      bus_rd(3'd4, d); check("R4 mode", d, 16'h8000);

      // R7 auto-reload, p=1, L=3, armed
      bus_wr(3'd2, 16'd3, t);
      bus_wr(3'd0, 16'h0380, t);
      expect_pulse(t + 12, 1'b1, "R7");
      expect_pulse(t + 24, 1'b1, "R7");
      while (cyc < t + 26) @(negedge clk);
      bus_wr(3'd0, 16'h0000, t2);
      // R12 stopped: count frozen, no pulses
      bus_rd(3'd2, d);
      repeat (60) @(negedge clk);
      bus_rd(3'd2, d2);
      check("R12 frozen count", d2, d);
      drain(5);

      // R8 no auto-reload: stays at zero, armed so rst_req fires
      bus_wr(3'd2, 16'd2, t);
      bus_wr(3'd0, 16'h0080, t);
      expect_pulse(t + 4, 1'b1, "R8");
      drain(20);
      repeat (30) @(negedge clk);
      bus_rd(3'd2, d); check("R8 count at zero", d, 16'h0000);
      bus_wr(3'd0, 16'h0000, t);

      // R9 zero load while armed
      bus_wr(3'd2, 16'h0000, t);
      expect_pulse(t, 1'b1, "R9");
      drain(10);

      // R10 lone confirm has no effect
      bus_wr(3'd4, 16'h00A0, t);
      bus_rd(3'd4, d); check("R10 lone confirm", d, 16'h8000);
      // R11 interrupted key sequence
      bus_wr(3'd4, 16'h00F5, t);
      bus_wr(3'd4, 16'h0012, t);
      bus_wr(3'd4, 16'h00A0, t);
      bus_rd(3'd4, d); check("R11 cancelled key", d, 16'h8000);
      // R10 proper key sequence
      bus_wr(3'd4, 16'h00F5, t);
      bus_wr(3'd4, 16'h00A0, t);
      bus_rd(3'd4, d); check("R10 disarmed", d, 16'h0000);

      // R9 zero load while disarmed: no pulse
      p0 = n_pulse;
      bus_wr(3'd2, 16'h0000, t);
      repeat (20) @(negedge clk);
      check("R9 disarmed zero load", n_pulse, p0);

      // R3 R6 max prescale p=7, L=2, disarmed
      bus_wr(3'd2, 16'd2, t);
      bus_wr(3'd0, 16'h0E80, t);
      bus_rd(3'd0, d); check("R3 ctrl readback", d, 16'h0E80);
      expect_pulse(t + 512, 1'b0, "R6");
      drain(700);
      bus_wr(3'd0, 16'h0000, t);
      repeat (10) @(negedge clk);

      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule